// File: doc/BRIEF.md
# Dual-Bus Streaming Synchronous SRAM

This block is a single-clock static memory with two 9-bit data ports. One faces a local processor bus and the other faces a shared system bus. Each port word is 8 data bits plus a parity bit, and the memory stores and moves the parity bit exactly like the data bits. The address is registered on the falling clock edge. The write strobe, the two port input strobes and both ports' input data are registered on the rising edge. Each port's result sits in its own output latch. The latch follows its source while the clock is high and holds while the clock is low. Each port drives only while its asynchronous, active-low output enable is low.

Besides plain reads and writes, the block forwards a word from one bus to the other. The word registered at the inbound port is placed in the opposite port's output latch. When the write strobe is also low, the same word is written into the array. When the write strobe is high, the array is not touched. Bidirectional pins are split into data-in, data-out and drive-enable signals, and the array depth is set by a parameter. A contention flag reports when software has enabled a port's output driver while that port is taking in data.

Top module: `dual_bus_sram`

## Requirements
- R1: The address is sampled on the falling clock edge. A read registered at the following rising edge returns the word stored at that address during the clock-high phase that follows.
- R2: With write strobe high and both input strobes high, the array word goes to every port whose output enable is low. When both enables are low, both ports carry the same word.
- R3: Each output enable is asynchronous and active low. Raising it turns off that port's driver without waiting for a clock edge, and lowering it again restores the latched word.
- R4: A write occurs only when the registered write strobe is low and exactly one input strobe is low. All 9 bits (parity bit 8 included) are taken from that port's input register and stored at the registered address.
- R5: When both input strobes are low, or when the write strobe is low with both input strobes high, nothing is written and neither port drives.
- R6: A port whose input strobe was registered low never drives, whatever the state of its output enable.
- R7: With exactly one input strobe low, the word registered at that port is driven on the other port when that port's output enable is low. When the write strobe is low, the word is also written.
- R8: Forwarding with the write strobe high leaves the array contents unchanged.
- R9: `contention` is high exactly when one input strobe is registered low, the other is registered high, and the inbound port's output enable is low. The inbound port stays undriven.
- R10: While reset is applied and just after it is released, neither port drives and `contention` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address on falling edge, controls and data on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address |
| we_n | input | 1 | Write strobe, active low |
| p_ie_n | input | 1 | Processor port input strobe, active low |
| s_ie_n | input | 1 | System port input strobe, active low |
| p_oe_n | input | 1 | Processor port output enable, asynchronous, active low |
| s_oe_n | input | 1 | System port output enable, asynchronous, active low |
| p_din | input | DATA_W+1 | Processor port incoming word (bit DATA_W is parity) |
| p_dout | output | DATA_W+1 | Processor port outgoing word |
| p_doe | output | 1 | Processor port drive enable |
| s_din | input | DATA_W+1 | System port incoming word (bit DATA_W is parity) |
| s_dout | output | DATA_W+1 | System port outgoing word |
| s_doe | output | 1 | System port drive enable |
| contention | output | 1 | Inbound port has its output enable low |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8, which gives a 16-word array. With that depth, every location is written from alternating ports before any read. Reads then reach both address extremes (0 and 15), and after every forwarding cycle and every no-operation cycle the affected word is read back. The 9-bit word lets patterns with the parity bit set show that bit 8 travels through both the store path and the forwarding path.

// File: rtl/dbsram_pkg.sv
`timescale 1ns/1ps
package dbsram_pkg;
  localparam int NPORT = 2;
  localparam int PORT_P = 0;
  localparam int PORT_S = 1;

  // Source selected for a port's output latch in the current cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_PEER  = 2'd2
  } src_e;
endpackage

// File: rtl/dbsram_decode.sv
`timescale 1ns/1ps
module dbsram_decode
  import dbsram_pkg::*;
(
  input  logic       we_n_q,
  input  logic       p_ien_q,
  input  logic       s_ien_q,
  output logic       wr_en,
  output logic       wr_from_s,
  output src_e       p_src,
  output src_e       s_src
);
  logic rd_cyc;
  logic p_inbound;
  logic s_inbound;

  always_comb begin
    rd_cyc    = we_n_q & p_ien_q & s_ien_q;
    p_inbound = ~p_ien_q & s_ien_q;
    s_inbound = p_ien_q & ~s_ien_q;
    wr_en     = ~we_n_q & (p_inbound | s_inbound);
    wr_from_s = s_inbound;

    p_src = SRC_NONE;
    s_src = SRC_NONE;
    if (rd_cyc) begin
      p_src = SRC_ARRAY;
      s_src = SRC_ARRAY;
    end else if (s_inbound) begin
      p_src = SRC_PEER;
    end else if (p_inbound) begin
      s_src = SRC_PEER;
    end
  end
endmodule

// File: rtl/dbsram_array.sv
`timescale 1ns/1ps
module dbsram_array #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Self-timed write: commits at the end of the clock-high phase,
  // using the address registered on the previous falling edge.
  always_ff @(negedge clk) begin
    if (wr_en) begin
      mem[addr_q] <= wdata;
    end
  end

  assign rdata = mem[addr_q];
endmodule

// File: rtl/dbsram_port.sv
`timescale 1ns/1ps
module dbsram_port
  import dbsram_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] d_in,
  input  logic              ien,
  input  logic              oe_n,
  input  src_e              src,
  input  logic [WORD_W-1:0] array_word,
  input  logic [WORD_W-1:0] peer_word,
  output logic [WORD_W-1:0] d_in_q,
  output logic              ien_q,
  output logic [WORD_W-1:0] d_out,
  output logic              d_oe
);
  logic [WORD_W-1:0] d_in_nxt;
  logic              ien_nxt;
  logic [WORD_W-1:0] sel_word;
  logic              sel_valid;
  logic [WORD_W-1:0] lat_word;
  logic              lat_valid;

  always_comb begin
    d_in_nxt = d_in;
    ien_nxt  = ien;
  end

  // Input register; reset marks the port as taking in data (quiet)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_in_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      d_in_q <= d_in_nxt;
      ien_q  <= ien_nxt;
    end
  end

  always_comb begin
    sel_valid = (src != SRC_NONE);
    sel_word  = (src == SRC_ARRAY) ? array_word : peer_word;
  end

  // Output latch: open while the clock is high, closed while low
  always_latch begin
    if (!rst_n) begin
      lat_valid <= 1'b0;
      lat_word  <= '0;
    end else if (clk) begin
      lat_valid <= sel_valid;
      lat_word  <= sel_word;
    end
  end

  assign d_out = lat_word;
  assign d_oe  = lat_valid & ~oe_n;

  // R6: inbound port never drives
  p_quiet_inbound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !d_oe);
endmodule

// File: rtl/dual_bus_sram.sv
`timescale 1ns/1ps
module dual_bus_sram
  import dbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_n,
  input  logic              p_ie_n,
  input  logic              s_ie_n,
  input  logic              p_oe_n,
  input  logic              s_oe_n,
  input  logic [DATA_W:0]   p_din,
  output logic [DATA_W:0]   p_dout,
  output logic              p_doe,
  input  logic [DATA_W:0]   s_din,
  output logic [DATA_W:0]   s_dout,
  output logic              s_doe,
  output logic              contention
);
  localparam int WORD_W = DATA_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  logic              we_n_q;
  logic              we_n_nxt;
  logic              wr_en;
  logic              wr_from_s;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] rdata;
  src_e              src_a   [NPORT];
  logic [WORD_W-1:0] din_a   [NPORT];
  logic              ien_a   [NPORT];
  logic              oen_a   [NPORT];
  logic [WORD_W-1:0] dinq_a  [NPORT];
  logic              ienq_a  [NPORT];
  logic [WORD_W-1:0] dout_a  [NPORT];
  logic              doe_a   [NPORT];

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Address register on the falling edge
  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) addr_q <= '0;
    else             addr_q <= addr;
  end

  always_comb we_n_nxt = we_n;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) we_n_q <= 1'b1;
    else             we_n_q <= we_n_nxt;
  end

  assign din_a[PORT_P] = p_din;
  assign din_a[PORT_S] = s_din;
  assign ien_a[PORT_P] = p_ie_n;
  assign ien_a[PORT_S] = s_ie_n;
  assign oen_a[PORT_P] = p_oe_n;
  assign oen_a[PORT_S] = s_oe_n;

  dbsram_decode u_decode (
    .we_n_q    (we_n_q),
    .p_ien_q   (ienq_a[PORT_P]),
    .s_ien_q   (ienq_a[PORT_S]),
    .wr_en     (wr_en),
    .wr_from_s (wr_from_s),
    .p_src     (src_a[PORT_P]),
    .s_src     (src_a[PORT_S])
  );

  genvar g;
  for (g = 0; g < NPORT; g++) begin : g_port
    dbsram_port #(.WORD_W(WORD_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .d_in       (din_a[g]),
      .ien        (ien_a[g]),
      .oe_n       (oen_a[g]),
      .src        (src_a[g]),
      .array_word (rdata),
      .peer_word  (dinq_a[NPORT-1-g]),
      .d_in_q     (dinq_a[g]),
      .ien_q      (ienq_a[g]),
      .d_out      (dout_a[g]),
      .d_oe       (doe_a[g])
    );
  end

  assign wdata = wr_from_s ? dinq_a[PORT_S] : dinq_a[PORT_P];

  dbsram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk    (clk),
    .addr_q (addr_q),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata)
  );

  assign p_dout = dout_a[PORT_P];
  assign p_doe  = doe_a[PORT_P];
  assign s_dout = dout_a[PORT_S];
  assign s_doe  = doe_a[PORT_S];

  assign contention = (~ienq_a[PORT_P] &  ienq_a[PORT_S] & ~p_oe_n)
                    | ( ienq_a[PORT_P] & ~ienq_a[PORT_S] & ~s_oe_n);

  // R2: a read driven on both ports carries one word
  p_dual_read_same_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (we_n_q && ienq_a[PORT_P] && ienq_a[PORT_S] && p_doe && s_doe)
      |-> (p_dout == s_dout));

  // R5: no-operation cycles leave both ports quiet
  p_nop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ienq_a[PORT_P] == ienq_a[PORT_S]) && !(we_n_q && ienq_a[PORT_P]))
      |-> (!p_doe && !s_doe && !wr_en));

  // R4: array writes only with exactly one inbound port
  p_single_writer_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (!we_n_q && (ienq_a[PORT_P] != ienq_a[PORT_S])));

  // R7: forwarded word on the system side equals the processor input register
  p_fwd_to_sys_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ienq_a[PORT_P] && ienq_a[PORT_S] && s_doe) |-> (s_dout == dinq_a[PORT_P]));

  // R9: a flagged contention never lets both ports drive
  p_contention_safe_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    contention |-> !(p_doe && s_doe));
endmodule

// File: tb/dual_bus_sram_tb.sv
`timescale 1ns/1ps
module dual_bus_sram_tb;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int W     = DW + 1;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we_n, p_ie_n, s_ie_n, p_oe_n, s_oe_n;
  logic [W-1:0]  p_din, s_din, p_dout, s_dout;
  logic          p_doe, s_doe, contention;

  always #4 clk = ~clk;  // 125 MHz

  dual_bus_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n),
    .p_ie_n(p_ie_n), .s_ie_n(s_ie_n), .p_oe_n(p_oe_n), .s_oe_n(s_oe_n),
    .p_din(p_din), .p_dout(p_dout), .p_doe(p_doe),
    .s_din(s_din), .s_dout(s_dout), .s_doe(s_doe),
    .contention(contention)
  );

  typedef struct {
    logic         pdrv;
    logic [W-1:0] pdat;
    logic         sdrv;
    logic [W-1:0] sdat;
    logic         cont;
    int unsigned  due;
    string        req;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] ref_mem [DEPTH];
  int unsigned  cyc = 0;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as their cycle comes up
  always begin
    @(posedge clk);
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(p_doe == e.pdrv, e.req, "p_doe", W'(p_doe), W'(e.pdrv));
      if (e.pdrv) chk(p_dout == e.pdat, e.req, "p_dout", p_dout, e.pdat);
      chk(s_doe == e.sdrv, e.req, "s_doe", W'(s_doe), W'(e.sdrv));
      if (e.sdrv) chk(s_dout == e.sdat, e.req, "s_dout", s_dout, e.sdat);
      chk(contention == e.cont, e.req, "contention", W'(contention), W'(e.cont));
    end
  end

  // Driver: applies one operation, predicts outputs from the requirements
  task automatic op(input logic [AW-1:0] a, input logic wen, input logic pien,
                    input logic sien, input logic [W-1:0] pd, input logic [W-1:0] sd,
                    input logic poen, input logic soen, input string req);
    exp_t e;
    logic rd;
    @(posedge clk);
    #1;
    addr = a; we_n = wen; p_ie_n = pien; s_ie_n = sien;
    p_din = pd; s_din = sd; p_oe_n = poen; s_oe_n = soen;
    rd     = wen & pien & sien;
    e.pdrv = ~poen & pien & (rd | ~sien);
    e.pdat = rd ? ref_mem[a] : sd;
    e.sdrv = ~soen & sien & (rd | ~pien);
    e.sdat = rd ? ref_mem[a] : pd;
    e.cont = (~pien & sien & ~poen) | (pien & ~sien & ~soen);
    e.due  = cyc + 1;
    e.req  = req;
    sb.push_back(e);
    if (!wen && (pien ^ sien)) ref_mem[a] = pien ? sd : pd;
    @(posedge clk);
    #3;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; we_n = 1'b1; p_ie_n = 1'b1; s_ie_n = 1'b1;
    p_oe_n = 1'b1; s_oe_n = 1'b1; p_din = '0; s_din = '0;
    repeat (2) @(posedge clk);
    #2;
    p_oe_n = 1'b0; s_oe_n = 1'b0;
    #1;
    // R10: in reset with enables low, nobody drives
    chk(!p_doe && !s_doe, "R10", "drive in reset", W'({p_doe, s_doe}), '0);
    chk(!contention, "R10", "contention in reset", W'(contention), '0);
    p_oe_n = 1'b1; s_oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(!p_doe && !s_doe && !contention, "R10", "after release",
        W'({p_doe, s_doe, contention}), '0);

    // R4: fill every word, alternating source port, parity bit exercised
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0)
        op(AW'(i), 1'b0, 1'b0, 1'b1, W'(9'h100 | (i * 7)), W'(9'h0FF), 1'b1, 1'b1, "R4");
      else
        op(AW'(i), 1'b0, 1'b1, 1'b0, W'(9'h055), W'(9'h1A0 ^ i), 1'b1, 1'b1, "R4");
    end

    // R1/R2: reads to each port, both ports, and neither
    op(4'd0,  1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b1, "R1");
    op(4'd15, 1'b1, 1'b1, 1'b1, '0, '0, 1'b1, 1'b0, "R1");
    op(4'd7,  1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R2");
    op(4'd8,  1'b1, 1'b1, 1'b1, '0, '0, 1'b1, 1'b1, "R2");
    op(4'd3,  1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R2");

    // R3: output enable acts without a clock edge
    op(4'd2, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b1, "R3");
    p_oe_n = 1'b1;
    #0.5;
    chk(!p_doe, "R3", "p_doe after oe high", W'(p_doe), '0);
    p_oe_n = 1'b0;
    #0.5;
    chk(p_doe && (p_dout == ref_mem[2]), "R3", "p_dout after oe low", p_dout, ref_mem[2]);

    // R7: write-through processor to system, then allocate with forward
    op(4'd5,  1'b0, 1'b0, 1'b1, 9'h1C3, 9'h000, 1'b1, 1'b0, "R7");
    op(4'd5,  1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b1, "R7");
    op(4'd10, 1'b0, 1'b1, 1'b0, 9'h000, 9'h13C, 1'b0, 1'b1, "R7");
    op(4'd10, 1'b1, 1'b1, 1'b1, '0, '0, 1'b1, 1'b0, "R7");

    // R8: forward only, both directions, array untouched
    op(4'd12, 1'b1, 1'b0, 1'b1, 9'h1EE, 9'h000, 1'b1, 1'b0, "R8");
    op(4'd12, 1'b1, 1'b1, 1'b0, 9'h000, 9'h011, 1'b0, 1'b1, "R8");
    op(4'd12, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R8");

    // R5: both strobes low, and write strobe low with both high
    op(4'd4, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h1FF, 1'b0, 1'b0, "R5");
    op(4'd6, 1'b0, 1'b1, 1'b1, 9'h0AA, 9'h0AA, 1'b0, 1'b0, "R5");
    op(4'd4, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R5");
    op(4'd6, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R5");

    // R6/R9: inbound port with its enable low stays quiet, flag raised
    op(4'd9, 1'b0, 1'b0, 1'b1, 9'h177, 9'h000, 1'b0, 1'b0, "R9");
    op(4'd9, 1'b1, 1'b1, 1'b0, 9'h000, 9'h0C5, 1'b0, 1'b0, "R6");
    op(4'd9, 1'b1, 1'b0, 1'b1, 9'h0C6, 9'h000, 1'b0, 1'b1, "R9");
    op(4'd9, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0, "R4");

    // R1: back-to-back address extremes after updates
    op(4'd15, 1'b0, 1'b1, 1'b0, 9'h000, 9'h1B1, 1'b1, 1'b1, "R4");
    op(4'd0,  1'b1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b1, "R1");
    op(4'd15, 1'b1, 1'b1, 1'b1, '0, '0, 1'b1, 1'b0, "R1");

    repeat (3) @(posedge clk);
    #3;
    chk(sb.size() == 0, "R1", "scoreboard drained", W'(sb.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule